// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block collects level-sensitive interrupt requests from up to 64 hardware-numbered sources. It masks them and picks one winner for each of two request lines, a high line and a low line. Sources belong to six priority groups: four core groups W, X, Y and Z, and two auxiliary groups A and B. Inside a group, each source has a small position code. Every group has a priority register with eight slots. Each slot names a position code, so software decides which source sits at which priority level.

The two lines are fed from the same scan. Slots 1 and 2 of any group can each be steered to the high line. Every other slot always goes to the low line. A global configuration register does three things:
- It names one source that beats everything else, and steers it to either line.
- It chooses, per group, between a grouped ordering and a spread ordering.
- It holds the spread enable bits at fixed positions (see R9).

Winners are published as 6-bit vectors and as registered request lines. Software reaches all registers through a simple 32-bit word read/write port. The most significant bit of every word is bit 31.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the following hold:
  - both request lines are low and both vectors are 0;
  - the mask, routing and configuration registers read 0;
  - every priority register reads the identity layout, where slot n holds code n-1. This is the value 0x05003977.
- R2: A source is enabled only while its mask bit is 1. The bit positions are: source 1..3 at mask0 bits 15..13, source 10..15 at mask0 bits 6..1, source 32..36 at mask0 bits 31..27, source 40..43 at mask0 bits 23..20, source 20 at mask1 bit 28, and source 25..28 at mask1 bits 23..20. A mask write changes the request lines on the clock edge after the write edge.
- R3: Each vector register holds the winning source number in bits 31:26, with all other bits 0. The value 0 means nothing is pending on that line. A read returns data on the edge after the read strobe.
- R4: Requests are level sensitive. A line stays asserted while an enabled winning source stays active. It drops one edge after the source goes inactive.
- R5: Each slot holds a 3-bit code. Slots 1..3 sit at bits 31:29, 28:26 and 25:23. Slots 4..8 sit at bits 14:12, 11:9, 8:6, 5:3 and 2:0. The source for a slot is the group base plus the code. The bases are: W=1 (codes 0-2), X=32 (codes 0-4), Y=40 (codes 0-3), Z=9 (codes 1-6), A=17 (code 3 only) and B=25 (codes 0-3). In grouped mode, groups rank W, X, Y, Z, A, B, and within a group a lower slot number wins.
- R6: A slot whose code names a position with no implemented source never produces a request. This holds even when the matching input bit is active.
- R7: The routing registers use 2-bit fields, where 01 means high and every other value means low. Core routing register: W at bits 27:26 (slot 1) and 25:24 (slot 2), X at 19:18 and 17:16, Y at 11:10 and 9:8, Z at 3:2 and 1:0. Auxiliary routing register: A at 11:10 and 9:8, B at 3:2 and 1:0. Slots 3 to 8 always go to the low line.
- R8: Configuration bits 5:0 name an override source, where 0 means none. Bits 9:8 steer it, with 01 meaning high and anything else meaning low. While the override source is enabled and active, it wins its line. It never appears on the other line.
- R9: Configuration bit 16+g sets spread mode for group g, in the order W, X, Y, Z, A, B.
  - A slot s of a grouped group has rank 8g+s-1.
  - A slot s of a spread group has rank 6(s-1)+g.
  - The lowest rank wins. A tie goes to the lower group number.
- R10: The register word addresses are: 0 config, 1 mask0, 2 mask1, 3..8 priority registers for W, X, Y, Z, A and B, 9 core routing, 10 auxiliary routing, 11 low vector, 12 high vector. Every writable register reads back the value that was written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| src_lvl | input | 64 | Source levels, indexed by hardware number |
| irq_hi | output | 1 | High request line |
| irq_lo | output | 1 | Low request line |

## Verification
The high and low lines are chosen in the same scan, so two winners can be settled in one cycle. The bench provokes this in two ways:
- It routes slot 1 of a group high and leaves slot 2 low. It then keeps both sources active together and checks that each vector names its own source in that cycle.
- It sets an override source while an ordinary source is active, first steered to the high line and then to the low line. It checks that the override takes only its own line and that the ordinary source keeps or loses the other line as the ranking says.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int NGRP   = 6;
  localparam int NSLOT  = 8;
  localparam int CODE_W = 3;
  localparam int SRC_W  = 6;
  localparam int NSRC   = 1 << SRC_W;
  localparam int DW     = 32;
  localparam int AW     = 4;
  localparam int RANK_W = 6;
  localparam int CMP_W  = RANK_W + 2 * CODE_W;

  // Per-group layout: source base, implemented codes, mask register/top bit,
  // routing register/base shift. Order: W, X, Y, Z, A, B.
  localparam logic [SRC_W-1:0] GRP_BASE [NGRP] = '{6'd1, 6'd32, 6'd40, 6'd9, 6'd17, 6'd25};
  localparam logic [NSLOT-1:0] GRP_IMPL [NGRP] = '{8'h07, 8'h1F, 8'h0F, 8'h7E, 8'h08, 8'h0F};
  localparam int GRP_MREG  [NGRP] = '{0, 0, 0, 0, 1, 1};
  localparam int GRP_MTOP  [NGRP] = '{15, 31, 23, 7, 31, 23};
  localparam int GRP_RREG  [NGRP] = '{0, 0, 0, 0, 1, 1};
  localparam int GRP_RBASE [NGRP] = '{24, 16, 8, 0, 8, 0};

  localparam logic [AW-1:0] A_CFG   = 4'd0;
  localparam logic [AW-1:0] A_MASK0 = 4'd1;
  localparam logic [AW-1:0] A_MASK1 = 4'd2;
  localparam logic [AW-1:0] A_PRI0  = 4'd3;
  localparam logic [AW-1:0] A_RT0   = 4'd9;
  localparam logic [AW-1:0] A_RT1   = 4'd10;
  localparam logic [AW-1:0] A_VLO   = 4'd11;
  localparam logic [AW-1:0] A_VHI   = 4'd12;

  localparam int CFG_TOP_LSB    = 0;
  localparam int CFG_TROUTE_LSB = 8;
  localparam int CFG_SPREAD_LSB = 16;
  localparam logic [1:0] ROUTE_HIGH = 2'b01;

  // Bit position of the code field of slot index s (0-based).
  function automatic int slot_lsb(input int s);
    return (s < 3) ? (29 - 3 * s) : (21 - 3 * s);
  endfunction

  // Identity slot layout: slot s holds code s.
  function automatic logic [DW-1:0] pri_identity();
    logic [DW-1:0] v;
    v = '0;
    for (int s = 0; s < NSLOT; s++) v[slot_lsb(s) +: CODE_W] = CODE_W'(s);
    return v;
  endfunction
endpackage

// File: rtl/gic_regfile.sv
module gic_regfile
  import gic_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic [SRC_W-1:0]         vec_lo,
  input  logic [SRC_W-1:0]         vec_hi,
  output logic [DW-1:0]            rdata,
  output logic [DW-1:0]            cfg_q,
  output logic [1:0][DW-1:0]       mask_q,
  output logic [NGRP-1:0][DW-1:0]  pri_q,
  output logic [1:0][DW-1:0]       route_q
);
  localparam logic [DW-1:0] PRI_RST = pri_identity();
  localparam int VPAD = DW - SRC_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      mask_q  <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      if (addr == A_CFG)   cfg_q      <= wdata;
      if (addr == A_MASK0) mask_q[0]  <= wdata;
      if (addr == A_MASK1) mask_q[1]  <= wdata;
      if (addr == A_RT0)   route_q[0] <= wdata;
      if (addr == A_RT1)   route_q[1] <= wdata;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_pri
    localparam logic [AW-1:0] MY_ADDR = A_PRI0 + AW'(g);
    always_ff @(posedge clk) begin
      if (rst)                           pri_q[g] <= PRI_RST;
      else if (wr_en && addr == MY_ADDR) pri_q[g] <= wdata;
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr == A_CFG)   rd_mux = cfg_q;
    if (addr == A_MASK0) rd_mux = mask_q[0];
    if (addr == A_MASK1) rd_mux = mask_q[1];
    if (addr == A_RT0)   rd_mux = route_q[0];
    if (addr == A_RT1)   rd_mux = route_q[1];
    if (addr == A_VLO)   rd_mux = {vec_lo, VPAD'(0)};
    if (addr == A_VHI)   rd_mux = {vec_hi, VPAD'(0)};
    for (int g = 0; g < NGRP; g++)
      if (addr == A_PRI0 + AW'(g)) rd_mux = pri_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assert_vec_read_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_VLO) |=> (rdata == {$past(vec_lo), VPAD'(0)}));

  assert_mask_readback_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_MASK0) |=> (mask_q[0] == $past(wdata)));
endmodule

// File: rtl/gic_arbiter.sv
module gic_arbiter
  import gic_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSRC-1:0]          src_lvl,
  input  logic [DW-1:0]            cfg_q,
  input  logic [1:0][DW-1:0]       mask_q,
  input  logic [NGRP-1:0][DW-1:0]  pri_q,
  input  logic [1:0][DW-1:0]       route_q,
  output logic [SRC_W-1:0]         vec_lo_q,
  output logic [SRC_W-1:0]         vec_hi_q,
  output logic                     irq_lo_q,
  output logic                     irq_hi_q
);
  logic [SRC_W-1:0] top_num;
  logic             top_on, top_hit, top_to_hi;
  logic [1:0]       found;
  logic [CMP_W-1:0] best [2];
  logic [SRC_W-1:0] win  [2];

  assign top_num   = cfg_q[CFG_TOP_LSB +: SRC_W];
  assign top_on    = (top_num != '0);
  assign top_to_hi = (cfg_q[CFG_TROUTE_LSB +: 2] == ROUTE_HIGH);

  // Override source: enabled, implemented and active anywhere in the map.
  always_comb begin
    top_hit = 1'b0;
    for (int g = 0; g < NGRP; g++)
      for (int c = 0; c < NSLOT; c++)
        if (top_on && GRP_IMPL[g][c] && (GRP_BASE[g] + SRC_W'(c) == top_num)
            && mask_q[GRP_MREG[g]][GRP_MTOP[g] - c] && src_lvl[top_num])
          top_hit = 1'b1;
  end

  // Slot scan: every (group, slot) entry competes on its rank.
  always_comb begin
    logic [CODE_W-1:0] code;
    logic [SRC_W-1:0]  snum;
    logic              live, dst;
    logic [RANK_W-1:0] rank;
    logic [CMP_W-1:0]  cmp;
    found = '0;
    best[0] = '1; best[1] = '1;
    win[0]  = '0; win[1]  = '0;
    for (int g = 0; g < NGRP; g++) begin
      for (int s = 0; s < NSLOT; s++) begin
        code = pri_q[g][slot_lsb(s) +: CODE_W];
        snum = GRP_BASE[g] + SRC_W'(code);
        live = GRP_IMPL[g][code]
               && mask_q[GRP_MREG[g]][5'(GRP_MTOP[g] - int'(code))]
               && src_lvl[snum]
               && !(top_on && snum == top_num);
        dst  = (s < 2) &&
               (route_q[GRP_RREG[g]][GRP_RBASE[g] + ((s == 0) ? 2 : 0) +: 2] == ROUTE_HIGH);
        rank = cfg_q[CFG_SPREAD_LSB + g] ? RANK_W'(s * NGRP + g) : RANK_W'(g * NSLOT + s);
        cmp  = {rank, CODE_W'(g), CODE_W'(s)};
        if (live && (!found[dst] || cmp < best[dst])) begin
          found[dst] = 1'b1;
          best[dst]  = cmp;
          win[dst]   = snum;
        end
      end
    end
    if (top_hit) begin
      found[top_to_hi] = 1'b1;
      win[top_to_hi]   = top_num;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_lo_q <= '0;
      vec_hi_q <= '0;
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
    end else begin
      vec_lo_q <= found[0] ? win[0] : '0;
      vec_hi_q <= found[1] ? win[1] : '0;
      irq_lo_q <= found[0];
      irq_hi_q <= found[1];
    end
  end

  assert_idle_when_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (src_lvl == '0) |=> (!irq_lo_q && !irq_hi_q));

  assert_lo_winner_active_R4: assert property (@(posedge clk) disable iff (rst)
    irq_lo_q |-> ((($past(src_lvl) >> vec_lo_q) & NSRC'(1)) != '0));

  assert_vec_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    irq_hi_q |-> (vec_hi_q != '0));

  assert_override_high_R8: assert property (@(posedge clk) disable iff (rst)
    (top_hit && top_to_hi) |=> (irq_hi_q && vec_hi_q == $past(top_num) && vec_lo_q != $past(top_num)));
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import gic_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [3:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [63:0]     src_lvl,
  output logic            irq_hi,
  output logic            irq_lo
);
  logic [DW-1:0]           cfg_q;
  logic [1:0][DW-1:0]      mask_q;
  logic [NGRP-1:0][DW-1:0] pri_q;
  logic [1:0][DW-1:0]      route_q;
  logic [SRC_W-1:0]        vec_lo, vec_hi;

  gic_regfile u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr),
    .rd_en  (reg_rd),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .vec_lo (vec_lo),
    .vec_hi (vec_hi),
    .rdata  (reg_rdata),
    .cfg_q  (cfg_q),
    .mask_q (mask_q),
    .pri_q  (pri_q),
    .route_q(route_q)
  );

  gic_arbiter u_arb (
    .clk     (clk),
    .rst     (rst),
    .src_lvl (src_lvl),
    .cfg_q   (cfg_q),
    .mask_q  (mask_q),
    .pri_q   (pri_q),
    .route_q (route_q),
    .vec_lo_q(vec_lo),
    .vec_hi_q(vec_hi),
    .irq_lo_q(irq_lo),
    .irq_hi_q(irq_hi)
  );

  assert_all_masked_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (mask_q[0] == '0 && mask_q[1] == '0) |=> (!irq_lo && !irq_hi));
endmodule

// File: tb/grp_irq_ctrl_tb_top.sv
module grp_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] src = '0;
  logic        irq_hi, irq_lo;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [3:0] CFG = 0, M0 = 1, M1 = 2, PW = 3, PX = 4, PY = 5, PZ = 6, PB = 8,
                         RT0 = 9, VLO = 11, VHI = 12;

  always #2.5 clk = ~clk;

  grp_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_lvl(src),
    .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  function automatic logic [31:0] ident();
    return 32'h05003977;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src = '0; reg_wr = 0; reg_rd = 0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic chk_vec(input string req, input logic [3:0] a, input int exp_src);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, 32'(exp_src) << 26);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 irq_lo", 32'(irq_lo), 0);
    chk("R1 irq_hi", 32'(irq_hi), 0);
    rd(CFG, d); chk("R1 cfg", d, 0);
    rd(M0, d);  chk("R1 mask0", d, 0);
    rd(RT0, d); chk("R1 route", d, 0);
    rd(PZ, d);  chk("R1 pri Z identity", d, ident());
    chk_vec("R1 vec_lo", VLO, 0);
  endtask

  task automatic t_mask_level();
    logic [31:0] d;
    do_reset();
    src[1] = 1'b1; step();
    chk("R2 masked source quiet", 32'(irq_lo), 0);
    wr(M0, 32'h1 << 15);
    chk("R2 not yet (write edge)", 32'(irq_lo), 0);
    step();
    chk("R2 enabled next edge", 32'(irq_lo), 1);
    chk_vec("R3 vec_lo src1", VLO, 1);
    chk("R4 held while active", 32'(irq_lo), 1);
    @(negedge clk); src[1] = 1'b0; step();
    chk("R4 drop after removal", 32'(irq_lo), 0);
    chk_vec("R3 vec zero when idle", VLO, 0);
    wr(M0, 32'h8000_2000); rd(M0, d);
    chk("R10 mask0 readback", d, 32'h8000_2000);
  endtask

  task automatic t_group_order();
    logic [31:0] d;
    do_reset();
    wr(M0, 32'hFFFF_FFFF);
    src[33] = 1; src[12] = 1; step();
    chk_vec("R5 X beats Z", VLO, 33);
    @(negedge clk); src[2] = 1; step();
    chk_vec("R5 W beats X", VLO, 2);
    @(negedge clk); src = '0; src[32] = 1; src[34] = 1; step();
    chk_vec("R5 slot1 beats slot3", VLO, 32);
    wr(PX, 32'h4400_3977); step();
    chk_vec("R5 reprogrammed slots", VLO, 34);
    rd(PX, d); chk("R10 pri X readback", d, 32'h4400_3977);
  endtask

  task automatic t_unimpl();
    do_reset();
    wr(M0, 32'hFFFF_FFFF); wr(M1, 32'hFFFF_FFFF);
    wr(PW, 32'hA000_0000 | (ident() & 32'h1FFF_FFFF));
    src[9] = 1; src[17] = 1; src[6] = 1; step();
    chk("R6 unimplemented codes ignored", {30'd0, irq_hi, irq_lo}, 0);
  endtask

  task automatic t_route();
    do_reset();
    wr(M0, 32'hFFFF_FFFF);
    wr(RT0, 32'h0000_0400);
    src[40] = 1; src[41] = 1; step();
    chk("R7 high line up", 32'(irq_hi), 1);
    chk_vec("R7 slot1 on high", VHI, 40);
    chk_vec("R7 slot2 on low same cycle", VLO, 41);
    wr(RT0, 32'h0000_0C00); step();
    chk("R7 code 11 means low", 32'(irq_hi), 0);
    chk_vec("R7 slot1 back on low", VLO, 40);
    @(negedge clk); src = '0; src[42] = 1;
    wr(RT0, 32'hFFFF_FFFF); step();
    chk("R7 slot3 never high", 32'(irq_hi), 0);
    chk_vec("R7 slot3 on low", VLO, 42);
  endtask

  task automatic t_override();
    do_reset();
    wr(M0, 32'h1 << 15); wr(M1, 32'h1 << 20);
    wr(CFG, 32'h0000_011C);
    src[1] = 1; src[28] = 1; step();
    chk_vec("R8 override on high", VHI, 28);
    chk_vec("R8 ordinary on low", VLO, 1);
    wr(CFG, 32'h0000_001C); step();
    chk_vec("R8 override wins low", VLO, 28);
    chk("R8 nothing on high", 32'(irq_hi), 0);
    wr(M1, 32'h0); step();
    chk_vec("R8 masked override yields", VLO, 1);
  endtask

  task automatic t_spread();
    do_reset();
    wr(M0, 32'hFFFF_FFFF);
    src[3] = 1; src[32] = 1; step();
    chk_vec("R9 grouped: W slot3 wins", VLO, 3);
    wr(CFG, 32'h1 << 17); step();
    chk_vec("R9 X spread slot1 wins", VLO, 32);
    wr(CFG, 32'h1 << 16); step();
    chk_vec("R9 W spread slot3 loses", VLO, 32);
    wr(CFG, 32'h3 << 16); step();
    chk_vec("R9 both spread", VLO, 32);
    wr(PB, ident());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mask_level();
    t_group_order();
    t_unimpl();
    t_route();
    t_override();
    t_spread();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule